// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a single-data-rate SDRAM command bus and watches the control pins on every rising clock edge. It turns chip select, the three strobes, the bank select pair and the auto-precharge address bit into one named command. It also keeps, for each bank, whether a row is open and which row that is. Commands that break the bank protocol raise a one-cycle error pulse, so the block can act as the front end of a memory model or as a passive bus monitor.

A command counts only when clock enable was high at the edge before. The burst length held by the mode register sets how long an auto-precharge access keeps its bank open. All outputs come from registers. The command vector, bank index and error pulse for a command sampled at edge N can be read after edge N. Bank state updated at edge N can also be read after edge N.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While `rst` is high, and after it falls until a command is accepted, `cmd_vec` and `err` are zero, all banks are idle and every stored row is zero.
- R2: An accepted command sets exactly one bit of `cmd_vec`. The pins {cs_n,ras_n,cas_n,we_n} decode as follows: 1xxx deselect bit 0; 0111 no-op bit 1; 0110 burst stop bit 2; 0101 read bit 3; 0100 write bit 5; 0011 activate bit 7; 0010 precharge bit 8; 0001 refresh bit 10; 0000 mode set bit 11.
- R3: For read and write, `addr[10]` high selects the auto-precharge form: bit 4 for read and bit 6 for write. For precharge, `addr[10]` high selects all banks (bit 9).
- R4: If `cke` was low at the previous edge, the command at this edge is dropped. `cmd_vec` reads zero and no bank state changes.
- R5: An activate to an idle bank opens it and stores `addr` (13 bits) as its row. An activate to an open bank raises `err` and leaves the bank's row unchanged.
- R6: A single-bank precharge closes only the bank given by `ba`, where `ba` = {BA1,BA0} selects banks 0 to 3. Precharge-all closes every bank. Precharging an idle bank is not an error.
- R7: A read or write to an idle bank raises `err`. A read or write without auto precharge to an open bank leaves it open with its row unchanged.
- R8: An auto-precharge read or write that is accepted at edge N closes its bank at edge N+BL. While that close is pending, any read or write to the bank raises `err`.
- R9: A refresh raises `err` unless every bank is idle. A refresh never opens a bank.
- R10: A mode set with `ba` = 0, `addr[10]` = 0 and `addr[2:0]` in 0..3 sets BL to 1, 2, 4 or 8. Any other mode set raises `err` and keeps BL. BL is 4 after reset.
- R11: `err` is high for exactly one cycle after each erroneous command and low after each legal command.
- R12: `cmd_bank` shows the `ba` value that was sampled with the command now shown on `cmd_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; gates the command at the next edge |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address; row for activate, bit 10 qualifier, bits 2:0 length code |
| cmd_vec | output | 12 | One-hot decoded command |
| cmd_bank | output | 2 | Bank index sampled with the command |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 52 | Stored rows, bank i at bits i*13 +: 13 |
| err | output | 1 | One-cycle protocol error pulse |

## Verification
Two functions can act in the same cycles: the auto-precharge countdown of a bank, and the legality check of a new command that targets that bank. The bench issues an auto-precharge read and then, while that read's countdown is still running, a write to the same bank. It then expects an error pulse for the write, and it expects the bank to still close exactly BL edges after the read, with the countdown undisturbed. A second pairing comes from clock-enable gating together with decode: an activate that arrives one edge after `cke` fell must show an empty command vector and must leave the bank closed.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [3:0] {
    K_DESL = 4'd0,
    K_NOP  = 4'd1,
    K_BST  = 4'd2,
    K_RD   = 4'd3,
    K_RDA  = 4'd4,
    K_WR   = 4'd5,
    K_WRA  = 4'd6,
    K_ACT  = 4'd7,
    K_PRE  = 4'd8,
    K_PALL = 4'd9,
    K_REF  = 4'd10,
    K_MRS  = 4'd11
  } kind_t;
  localparam int KIND_N = 12;
  localparam int BL_W   = 4;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic  cs_n,
  input  logic  ras_n,
  input  logic  cas_n,
  input  logic  we_n,
  input  logic  ap_bit,
  output kind_t kind
);
  always_comb begin
    kind = K_DESL;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  kind = K_NOP;
        3'b110:  kind = K_BST;
        3'b101:  kind = ap_bit ? K_RDA : K_RD;
        3'b100:  kind = ap_bit ? K_WRA : K_WR;
        3'b011:  kind = K_ACT;
        3'b010:  kind = ap_bit ? K_PALL : K_PRE;
        3'b001:  kind = K_REF;
        default: kind = K_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_mode.sv
module sdcmd_mode
  import sdcmd_pkg::*;
#(
  parameter int BA_W        = 2,
  parameter int DEF_BL_CODE = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [BA_W-1:0] ba,
  input  logic            ap_bit,
  input  logic [2:0]      code,
  output logic [BL_W-1:0] bl,
  output logic            mrs_err
);
  logic ok;
  assign ok      = (ba == '0) && !ap_bit && !code[2];
  assign mrs_err = strobe && !ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      bl <= BL_W'(1) << DEF_BL_CODE;
    end else if (strobe && ok) begin
      bl <= BL_W'(1) << code[1:0];
    end
  end

  // R10: the length changes only after a well-formed mode set
  a_r10_bl_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(bl) |-> $past(strobe && ok));
  a_r10_bl_legal: assert property (@(posedge clk) disable iff (rst)
    $countones(bl) == 1);
endmodule

// File: rtl/sdcmd_bank_slot.sv
module sdcmd_bank_slot
  import sdcmd_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             is_act,
  input  logic             is_col,
  input  logic             is_ap,
  input  logic             is_pre_one,
  input  logic             is_pall,
  input  logic [ROW_W-1:0] row_in,
  input  logic [BL_W-1:0]  bl,
  output logic             open,
  output logic [ROW_W-1:0] row,
  output logic             cerr
);
  logic [BL_W-1:0] cnt;
  logic            pend;
  logic            act_ok;
  logic            col_ok;
  logic            close_now;

  assign pend      = (cnt != '0);
  assign act_ok    = sel && is_act && !open;
  assign col_ok    = sel && is_col && open && !pend;
  assign close_now = is_pall || (sel && is_pre_one);
  assign cerr      = sel && ((is_act && open) || (is_col && (!open || pend)));

  always_ff @(posedge clk) begin
    if (rst) begin
      open <= 1'b0;
      row  <= '0;
      cnt  <= '0;
    end else if (close_now) begin
      open <= 1'b0;
      cnt  <= '0;
    end else if (act_ok) begin
      open <= 1'b1;
      row  <= row_in;
    end else if (col_ok && is_ap) begin
      cnt <= bl;
    end else if (pend) begin
      cnt <= cnt - 1'b1;
      if (cnt == BL_W'(1)) open <= 1'b0;
    end
  end

  // R5: an accepted activate opens the bank with the presented row
  a_r5_act_latch: assert property (@(posedge clk) disable iff (rst)
    (sel && is_act && !open) |=> (open && row == $past(row_in)));
  // R8: a bank closes only by precharge or by the end of its countdown
  a_r8_close_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(open) |-> $past(is_pall || (sel && is_pre_one) || cnt == BL_W'(1)));
  // R5: an open bank keeps its row unless it is closed
  a_r5_row_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(open) && open) |-> $stable(row));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int ROW_W       = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10,
  parameter int DEF_BL_CODE = 2,
  localparam int NB         = 1 << BA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BA_W-1:0]     ba,
  input  logic [ROW_W-1:0]    addr,
  output logic [KIND_N-1:0]   cmd_vec,
  output logic [BA_W-1:0]     cmd_bank,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_rows,
  output logic                err
);
  logic            cke_q;
  kind_t           kind;
  logic [BL_W-1:0] bl;
  logic            mrs_err;
  logic            is_act, is_col, is_ap, is_pre_one, is_pall, is_ref, is_mrs;
  logic [NB-1:0]   bank_err;
  logic            err_now;

  sdcmd_decode u_dec (
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ap_bit (addr[AP_BIT]),
    .kind   (kind)
  );

  assign is_act     = cke_q && (kind == K_ACT);
  assign is_col     = cke_q && (kind == K_RD || kind == K_RDA ||
                                kind == K_WR || kind == K_WRA);
  assign is_ap      = cke_q && (kind == K_RDA || kind == K_WRA);
  assign is_pre_one = cke_q && (kind == K_PRE);
  assign is_pall    = cke_q && (kind == K_PALL);
  assign is_ref     = cke_q && (kind == K_REF);
  assign is_mrs     = cke_q && (kind == K_MRS);

  sdcmd_mode #(.BA_W(BA_W), .DEF_BL_CODE(DEF_BL_CODE)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .strobe  (is_mrs),
    .ba      (ba),
    .ap_bit  (addr[AP_BIT]),
    .code    (addr[2:0]),
    .bl      (bl),
    .mrs_err (mrs_err)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    sdcmd_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .sel        (cke_q && (ba == BA_W'(i))),
      .is_act     (is_act),
      .is_col     (is_col),
      .is_ap      (is_ap),
      .is_pre_one (is_pre_one),
      .is_pall    (is_pall),
      .row_in     (addr),
      .bl         (bl),
      .open       (bank_open[i]),
      .row        (open_rows[i*ROW_W +: ROW_W]),
      .cerr       (bank_err[i])
    );
  end

  assign err_now = (|bank_err) || mrs_err || (is_ref && (|bank_open));

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q    <= 1'b0;
      cmd_vec  <= '0;
      cmd_bank <= '0;
      err      <= 1'b0;
    end else begin
      cke_q    <= cke;
      cmd_vec  <= cke_q ? (KIND_N'(1) << kind) : '0;
      cmd_bank <= ba;
      err      <= err_now;
    end
  end

  // R2: never more than one command named at a time
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_vec));
  // R4: a command after a low clock enable is dropped
  a_r4_gate: assert property (@(posedge clk) disable iff (rst)
    !cke_q |=> (cmd_vec == '0));
  // R9: an accepted refresh leaves every bank idle
  a_r9_ref_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_vec[int'(K_REF)] && !err) |-> (bank_open == '0));
endmodule

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] C_DESL = 4'b1111;
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_BST  = 4'b0110;
  localparam logic [3:0] C_RD   = 4'b0101;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_ACT  = 4'b0011;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_MRS  = 4'b0000;
  localparam logic [12:0] AP    = 13'h0400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [11:0] cmd_vec;
  logic [1:0]  cmd_bank;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;
  logic        err;

  int total = 0;
  int bad = 0;

  sdram_cmd_tracker uut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_vec(cmd_vec), .cmd_bank(cmd_bank), .bank_open(bank_open),
    .open_rows(open_rows), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic c, input logic [3:0] k, input logic [1:0] b,
                       input logic [12:0] a);
    cke = c;
    {cs_n, ras_n, cas_n, we_n} = k;
    ba = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [12:0] row_of(input int i);
    return open_rows[i*13 +: 13];
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 cmd_vec in reset", cmd_vec, 0);
    chk("R1 err in reset", err, 0);
    chk("R1 banks idle", bank_open, 0);
    chk("R1 rows zero", open_rows, 0);
    rst = 1'b0;
    issue(1, C_NOP, 0, 0);
    chk("R1 first edge dropped", cmd_vec, 0);
  endtask

  task automatic t_decode();
    issue(1, C_DESL, 0, 0);  chk("R2 deselect", cmd_vec, 12'h001);
    issue(1, C_NOP, 0, 0);   chk("R2 nop", cmd_vec, 12'h002);
    issue(1, C_BST, 0, 0);   chk("R2 burst stop", cmd_vec, 12'h004);
    issue(1, C_REF, 0, 0);   chk("R9 refresh idle code", cmd_vec, 12'h400);
    chk("R9 refresh idle no err", err, 0);
    issue(1, C_MRS, 0, 13'd2);
    chk("R10 mode set code", cmd_vec, 12'h800);
    chk("R10 legal mode no err", err, 0);
  endtask

  task automatic t_activate();
    issue(1, C_ACT, 2, 13'h1ABC);
    chk("R2 activate code", cmd_vec, 12'h080);
    chk("R12 bank index", cmd_bank, 2);
    chk("R5 bank opened", bank_open, 4'b0100);
    chk("R5 row stored", row_of(2), 13'h1ABC);
    issue(1, C_ACT, 2, 13'h0123);
    chk("R5 reopen err", err, 1);
    chk("R5 row kept", row_of(2), 13'h1ABC);
    issue(1, C_NOP, 0, 0);
    chk("R11 err one cycle", err, 0);
  endtask

  task automatic t_column();
    issue(1, C_RD, 2, 13'h0010);
    chk("R2 read code", cmd_vec, 12'h008);
    chk("R7 read open no err", err, 0);
    chk("R7 bank stays open", bank_open, 4'b0100);
    chk("R7 row unchanged", row_of(2), 13'h1ABC);
    issue(1, C_WR, 1, 13'h0010);
    chk("R2 write code", cmd_vec, 12'h020);
    chk("R7 write idle err", err, 1);
    chk("R12 write bank", cmd_bank, 1);
    issue(1, C_REF, 0, 0);
    chk("R9 refresh open err", err, 1);
    chk("R9 refresh keeps state", bank_open, 4'b0100);
  endtask

  task automatic t_precharge();
    issue(1, C_ACT, 0, 13'd5);
    issue(1, C_ACT, 3, 13'd7);
    chk("R5 three open", bank_open, 4'b1101);
    issue(1, C_PRE, 0, 0);
    chk("R2 precharge code", cmd_vec, 12'h100);
    chk("R6 only bank0 closed", bank_open, 4'b1100);
    issue(1, C_PRE, 1, 0);
    chk("R6 idle precharge no err", err, 0);
    issue(1, C_PRE, 1, AP);
    chk("R3 precharge all code", cmd_vec, 12'h200);
    chk("R6 all closed", bank_open, 0);
  endtask

  task automatic t_gate();
    issue(0, C_NOP, 0, 0);
    chk("R4 nop before cke low", cmd_vec, 12'h002);
    issue(1, C_ACT, 1, 13'd3);
    chk("R4 gated vector", cmd_vec, 0);
    chk("R4 gated no open", bank_open, 0);
    issue(1, C_ACT, 1, 13'd3);
    chk("R4 honoured again", bank_open, 4'b0010);
  endtask

  task automatic t_autopre();
    // bank1 open from t_gate; BL is 4
    issue(1, C_RD, 1, AP | 13'h0008);
    chk("R3 read auto code", cmd_vec, 12'h010);
    chk("R8 open after edge 0", bank_open[1], 1);
    issue(1, C_WR, 1, 0);
    chk("R8 access pending err", err, 1);
    issue(1, C_NOP, 0, 0);
    issue(1, C_NOP, 0, 0);
    chk("R8 open at edge 3", bank_open[1], 1);
    issue(1, C_NOP, 0, 0);
    chk("R8 closed at edge 4", bank_open[1], 0);
    issue(1, C_MRS, 0, 13'd0);
    issue(1, C_ACT, 3, 13'd9);
    issue(1, C_WR, 3, AP);
    chk("R3 write auto code", cmd_vec, 12'h040);
    chk("R8 bl1 open edge 0", bank_open[3], 1);
    issue(1, C_NOP, 0, 0);
    chk("R10 bl1 closes edge 1", bank_open[3], 0);
  endtask

  task automatic t_mode_bad();
    issue(1, C_MRS, 1, 13'd0);
    chk("R10 bank nonzero err", err, 1);
    issue(1, C_MRS, 0, AP);
    chk("R10 a10 set err", err, 1);
    issue(1, C_MRS, 0, 13'd5);
    chk("R10 code 5 err", err, 1);
    issue(1, C_ACT, 0, 13'd1);
    issue(1, C_RD, 0, AP);
    issue(1, C_NOP, 0, 0);
    chk("R10 length kept at 1", bank_open[0], 0);
    chk("R11 err cleared", err, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_activate();
    t_column();
    t_precharge();
    t_gate();
    t_autopre();
    t_mode_bad();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule